// File: doc/BRIEF.md
# Packet stream traffic generator

The block produces a framed byte stream for exercising downstream packet logic. After a start pulse it sends a requested number of packets and then stops. Each packet is a continuous burst of beats whose length is between 1 and 50 bytes. Before every packet comes a run of 3 to 6 idle cycles. The burst lengths, the idle gaps and the payload bytes all come from one free-running 16-bit linear feedback shift register. There is no flow control: the stream is never throttled.

Each cycle of the stream leaves the block as one packed 11-bit word that holds a valid flag, a first-beat flag, a last-beat flag and a data byte. When the requested number of packets has gone out, a done flag rises and stays high. A packet counter tracks progress. A new start pulse clears the counter, takes a fresh target and runs again.

Top module: `pkt_stream_gen`

## Requirements
- R1: While `rst_n` is low, `stream_word`, `done` and `pkts_sent` are all zero. Reset takes effect asynchronously, and no beat is sent until a start pulse arrives after reset is released.
- R2: `stream_word` bit 10 is valid, bit 9 is first-beat (sop), bit 8 is last-beat (eop) and bits 7:0 are the data byte. The first beat of a packet has sop high, the last beat has eop high, and any beat between them has both low. A one-beat packet has valid, sop and eop high together. sop and eop are never high while valid is low.
- R3: Valid stays high on every cycle from a packet's sop beat through its eop beat, so a packet has no idle cycles inside it.
- R4: Every packet is 1 to 50 beats long. Over a long run the lengths spread across that range.
- R5: Between an eop beat and the next sop beat there are 3 to 6 idle cycles, and every value in that range occurs. At least 3 idle cycles come between a start pulse and the first sop.
- R6: On every cycle where valid is low, the data byte is zero.
- R7: `pkts_sent` goes up by one on the same cycle as each eop beat. `done` rises on the cycle of the final eop beat and stays high until the next start pulse. No beat follows the final eop.
- R8: A start pulse seen while the block is idle or done clears `pkts_sent`, drops `done` and latches `pkt_target`. A target of zero raises `done` on the next cycle and sends no packet.
- R9: While packets are being sent, start pulses and changes to `pkt_target` have no effect. The run still ends after the target that was latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset. Asserts asynchronously and is released synchronously inside the block |
| start | input | 1 | One-cycle pulse that arms a new run |
| pkt_target | input | CNT_W (16) | Number of packets to send, latched on start |
| stream_word | output | 11 | {valid, sop, eop, data[7:0]} |
| done | output | 1 | High once the latched number of packets has been sent |
| pkts_sent | output | CNT_W (16) | Packets sent since the last start |

## Verification
A start pulse sampled on one edge changes the outputs from the next edge on. For a target of zero, done is therefore high one cycle after the pulse. After that, every stream beat, its matching `pkts_sent` step and the rising edge of `done` appear on the same cycle, because all three are registered on the same edge. The bench drives start just after a rising edge. It resets its own tracking immediately after the edge that samples start, and samples every output on the falling edge. This keeps the expected packet count, done level and idle-run length in step with the design, cycle for cycle. Targets from 0 to 6 and a longer run are swept, one run is disturbed by a stray start and a target change, and one run is cut off by reset.

// File: rtl/pkt_stream_gen_pkg.sv
package pkt_stream_gen_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned WORD_W = BYTE_W + 3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_GAP  = 2'd1,
    ST_DATA = 2'd2,
    ST_DONE = 2'd3
  } gen_state_e;

  typedef struct packed {
    logic              valid;
    logic              sop;
    logic              eop;
    logic [BYTE_W-1:0] data;
  } beat_t;
endpackage

// File: rtl/pkt_stream_gen_rst_sync.sv
module pkt_stream_gen_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/pkt_stream_gen_lfsr.sv
module pkt_stream_gen_lfsr #(
  parameter int unsigned       WIDTH = 16,
  parameter logic [WIDTH-1:0]  TAPS  = 16'hB400,
  parameter logic [WIDTH-1:0]  SEED  = 16'hACE1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  output logic [WIDTH-1:0] value
);
  logic [WIDTH-1:0] state_q;
  logic [WIDTH-1:0] state_d;

  always_comb begin
    state_d = {state_q[WIDTH-2:0], ^(state_q & TAPS)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEED;
    end else if (en) begin
      state_q <= state_d;
    end
  end

  assign value = state_q;
endmodule

// File: rtl/pkt_stream_gen_ctrl.sv
module pkt_stream_gen_ctrl
  import pkt_stream_gen_pkg::*;
#(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned RND_W    = 16,
  parameter int unsigned MAX_LEN  = 50,
  parameter int unsigned MIN_GAP  = 3,
  parameter int unsigned GAP_SPAN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] pkt_target,
  input  logic [RND_W-1:0] rnd,
  output beat_t            beat_d,
  output logic             done,
  output logic [CNT_W-1:0] pkts_sent
);
  localparam int unsigned LEN_W = $clog2(MAX_LEN + 1);
  localparam int unsigned GAP_W = $clog2(MIN_GAP + GAP_SPAN);

  gen_state_e       state_q, state_d;
  logic [GAP_W-1:0] gap_q, gap_d;
  logic [LEN_W-1:0] left_q, left_d;
  logic             first_q, first_d;
  logic [CNT_W-1:0] sent_q, sent_d;
  logic [CNT_W-1:0] target_q, target_d;

  logic [LEN_W-1:0] len_pick;
  logic [GAP_W-1:0] gap_pick;
  logic             last_beat;

  assign len_pick  = LEN_W'(rnd % RND_W'(MAX_LEN)) + LEN_W'(1);
  assign gap_pick  = GAP_W'(rnd % RND_W'(GAP_SPAN)) + GAP_W'(MIN_GAP);
  assign last_beat = (left_q == LEN_W'(1));

  always_comb begin
    state_d  = state_q;
    gap_d    = gap_q;
    left_d   = left_q;
    first_d  = first_q;
    sent_d   = sent_q;
    target_d = target_q;
    beat_d   = '0;
    case (state_q)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          target_d = pkt_target;
          sent_d   = '0;
          if (pkt_target == '0) begin
            state_d = ST_DONE;
          end else begin
            state_d = ST_GAP;
            gap_d   = gap_pick;
          end
        end
      end
      ST_GAP: begin
        gap_d = gap_q - GAP_W'(1);
        if (gap_q == GAP_W'(1)) begin
          state_d = ST_DATA;
          left_d  = len_pick;
          first_d = 1'b1;
        end
      end
      ST_DATA: begin
        beat_d.valid = 1'b1;
        beat_d.sop   = first_q;
        beat_d.eop   = last_beat;
        beat_d.data  = rnd[BYTE_W-1:0];
        first_d      = 1'b0;
        left_d       = left_q - LEN_W'(1);
        if (last_beat) begin
          sent_d = sent_q + CNT_W'(1);
          if (sent_q + CNT_W'(1) == target_q) begin
            state_d = ST_DONE;
          end else begin
            state_d = ST_GAP;
            gap_d   = gap_pick;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      gap_q    <= '0;
      left_q   <= '0;
      first_q  <= 1'b0;
      sent_q   <= '0;
      target_q <= '0;
    end else begin
      state_q  <= state_d;
      gap_q    <= gap_d;
      left_q   <= left_d;
      first_q  <= first_d;
      sent_q   <= sent_d;
      target_q <= target_d;
    end
  end

  assign done      = (state_q == ST_DONE);
  assign pkts_sent = sent_q;
endmodule

// File: rtl/pkt_stream_gen.sv
module pkt_stream_gen
  import pkt_stream_gen_pkg::*;
#(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned MAX_LEN  = 50,
  parameter int unsigned MIN_GAP  = 3,
  parameter int unsigned GAP_SPAN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  pkt_target,
  output logic [WORD_W-1:0] stream_word,
  output logic              done,
  output logic [CNT_W-1:0]  pkts_sent
);
  localparam int unsigned RND_W = 16;

  logic             rst_n_int;
  logic [RND_W-1:0] rnd;
  beat_t            beat_d;
  beat_t            beat_q;

  pkt_stream_gen_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  pkt_stream_gen_lfsr #(.WIDTH(RND_W)) u_lfsr (
    .clk   (clk),
    .rst_n (rst_n_int),
    .en    (1'b1),
    .value (rnd)
  );

  pkt_stream_gen_ctrl #(
    .CNT_W    (CNT_W),
    .RND_W    (RND_W),
    .MAX_LEN  (MAX_LEN),
    .MIN_GAP  (MIN_GAP),
    .GAP_SPAN (GAP_SPAN)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .start      (start),
    .pkt_target (pkt_target),
    .rnd        (rnd),
    .beat_d     (beat_d),
    .done       (done),
    .pkts_sent  (pkts_sent)
  );

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      beat_q <= '0;
    end else begin
      beat_q <= beat_d;
    end
  end

  assign stream_word = beat_q;
endmodule

// File: rtl/pkt_stream_gen_chk.sv
module pkt_stream_gen_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [10:0]      stream_word,
  input logic             done,
  input logic [CNT_W-1:0] pkts_sent
);
  logic vld, sop, eop;
  assign vld = stream_word[10];
  assign sop = stream_word[9];
  assign eop = stream_word[8];

  p_flags_need_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sop || eop) |-> vld);

  p_idle_data_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !vld |-> (stream_word[7:0] == 8'h00));

  p_no_bubble_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && !eop) |=> (vld && !sop));

  p_gap_after_eop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && eop) |=> !vld);

  p_done_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  p_quiet_after_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(done) && !$past(start)) |-> !vld);

  p_count_on_eop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((pkts_sent != $past(pkts_sent)) && !$past(start)) |-> (vld && eop));
endmodule

bind pkt_stream_gen pkt_stream_gen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .stream_word (stream_word),
  .done        (done),
  .pkts_sent   (pkts_sent)
);

// File: tb/pkt_stream_gen_tb.sv
`timescale 1ns/1ps
module pkt_stream_gen_tb;
  logic        clk;
  logic        rst_n;
  logic        start;
  logic [15:0] pkt_target;
  logic [10:0] stream_word;
  logic        done;
  logic [15:0] pkts_sent;

  pkt_stream_gen u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .pkt_target  (pkt_target),
    .stream_word (stream_word),
    .done        (done),
    .pkts_sent   (pkts_sent)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  bit armed    = 0;
  int tgt      = 0;
  int pkts_seen = 0;
  bit in_pkt   = 0;
  int cur_len  = 0;
  int idle_run = 0;
  bit had_pkt  = 0;
  int max_len  = 0;
  bit [3:0] gap_seen = '0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", cycles, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
    if (armed && rst_n) begin
      if (!stream_word[10]) begin
        chk(stream_word[9:8] == 2'b00, "R2 flags while idle", int'(stream_word[9:8]), 0);
        chk(stream_word[7:0] == 8'h00, "R6 idle data", int'(stream_word[7:0]), 0);
        if (in_pkt) chk(1'b0, "R3 bubble inside packet", 0, 1);
        in_pkt = 0;
        idle_run++;
      end else begin
        if (!in_pkt) begin
          chk(stream_word[9], "R2 sop on first beat", int'(stream_word[9]), 1);
          if (had_pkt) begin
            chk(idle_run >= 3 && idle_run <= 6, "R5 gap length", idle_run, 3);
            if (idle_run >= 3 && idle_run <= 6) gap_seen[idle_run-3] = 1'b1;
          end else begin
            chk(idle_run >= 3, "R5 gap after start", idle_run, 3);
          end
          chk(pkts_seen < tgt, "R7 beat after final packet", pkts_seen, tgt);
          cur_len = 1;
          in_pkt  = 1;
        end else begin
          chk(!stream_word[9], "R2 sop mid packet", int'(stream_word[9]), 0);
          cur_len++;
        end
        if (stream_word[8]) begin
          chk(cur_len >= 1 && cur_len <= 50, "R4 packet length", cur_len, 50);
          if (cur_len > max_len) max_len = cur_len;
          in_pkt = 0;
          pkts_seen++;
          idle_run = 0;
          had_pkt = 1;
        end else begin
          chk(cur_len < 50, "R4 packet too long", cur_len, 49);
        end
      end
      chk(int'(pkts_sent) == pkts_seen, "R7 pkts_sent", int'(pkts_sent), pkts_seen);
      chk(done == (pkts_seen == tgt), "R7 done level", int'(done), int'(pkts_seen == tgt));
    end
  end

  // R8: start pulse and tracking reset right after the sampling edge
  task automatic arm(input int t);
    @(posedge clk); #1;
    armed = 0;
    start = 1'b1;
    pkt_target = 16'(t);
    @(posedge clk); #1;
    start = 1'b0;
    tgt = t; pkts_seen = 0; in_pkt = 0; cur_len = 0; idle_run = 0; had_pkt = 0;
    armed = 1;
  endtask

  task automatic wait_done();
    int guard = 0;
    while (!done && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    chk(done, "R7 run completes", int'(done), 1);
    repeat (25) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    pkt_target = '0;
    repeat (3) @(negedge clk);
    // R1: outputs held at zero under reset
    chk(stream_word == 11'd0, "R1 word in reset", int'(stream_word), 0);
    chk(!done, "R1 done in reset", int'(done), 0);
    chk(pkts_sent == 16'd0, "R1 count in reset", int'(pkts_sent), 0);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (20) @(negedge clk);
    // R1: nothing sent without a start pulse
    chk(stream_word == 11'd0 && !done, "R1 quiet after release", int'(stream_word), 0);

    // R8, R2..R7: sweep of small targets, including zero
    for (int t = 0; t <= 6; t++) begin
      arm(t);
      wait_done();
    end

    // R9: stray start and target change mid-run
    arm(6);
    while (pkts_seen < 2) @(negedge clk);
    @(posedge clk); #1 start = 1'b1; pkt_target = 16'd2;
    @(posedge clk); #1 start = 1'b0;
    wait_done();
    chk(int'(pkts_sent) == 6, "R9 latched target kept", int'(pkts_sent), 6);

    // Longer run for length and gap spread
    arm(60);
    wait_done();
    chk(max_len > 25, "R4 length spread", max_len, 26);
    chk(gap_seen == 4'hF, "R5 all gap values", int'(gap_seen), 15);

    // R1: reset in the middle of a run acts at once
    arm(5);
    while (!stream_word[10]) @(negedge clk);
    armed = 0;
    @(posedge clk); #3 rst_n = 1'b0;
    #1;
    chk(stream_word == 11'd0, "R1 async reset word", int'(stream_word), 0);
    chk(pkts_sent == 16'd0 && !done, "R1 async reset count", int'(pkts_sent), 0);
    repeat (2) @(negedge clk);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (5) @(negedge clk);
    arm(2);
    wait_done();

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule